// File: doc/BRIEF.md
# Page Translation Cache with Overlapped Table Lookup

This block maps virtual addresses from a processor request port to physical addresses. It keeps a small fully associative set of page-to-frame mappings. Each accepted request starts a lookup on a slower memory-side port in the same cycle, before the block knows whether its cached mappings hold the answer. The memory side is treated as a page table that returns an entry for a page.

If a cached entry matches, the block returns the translated address from the cache and tells the memory side to drop the lookup already in progress. If no entry matches, the block waits for the memory-side reply and returns the address built from it. It also stores a present reply in a free or replaced entry, so that later references to any offset in that page are served locally. Every reply carries a present flag and a write-permission flag. Each response reports a fault when the page is absent, or when a write targets a page that does not allow writes.

One request is in flight at a time. A flush input empties the cache in a single cycle.

Top module: `xlat_cache`

## Requirements
- R1: A successful response has a physical address made of the frame number in the upper bits (bits 31:12) and the request's 12-bit in-page offset unchanged in the lower bits (bits 11:0).
- R2: In the cycle a request is accepted (req_valid and req_ready both high), walk_req_valid is high and walk_req_vpn equals address bits 31:12 of that request. walk_req_valid is never high in any other cycle.
- R3: On a cache hit, walk_cancel is high in the cycle after acceptance. In the cycle after that, rsp_valid is high and the response carries the cached translation.
- R4: On a miss, walk_cancel stays low and rsp_valid stays low until the memory reply arrives. rsp_valid rises in the cycle after walk_rsp_valid is sampled high. A walk_rsp_valid pulse seen while no miss is pending produces no response.
- R5: A present reply on a miss is installed. A later request to the same page with any offset hits, and its lookup is cancelled.
- R6: A reply with walk_rsp_present low gives rsp_fault high and rsp_paddr zero. It is not installed, so the next request to that page misses again.
- R7: A write request (req_write high) to a page whose write flag is low faults, both on a miss and on a hit. A read request to the same page translates normally.
- R8: A fill uses the lowest-numbered empty entry when one exists. When all 16 entries are full, it replaces the entry named by a rotating pointer. The pointer starts at entry 0 and advances by one after each such replacement.
- R9: A one-cycle flush pulse empties every entry, so each page cached before the flush misses afterwards.
- R10: req_ready is low from the cycle after acceptance until the response cycle. Only one request is outstanding at a time, and rsp_valid lasts one cycle per request.
- R11: After reset, req_ready is high, rsp_valid and walk_cancel are low, and the cache is empty, so the first request misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty every cached entry |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address (page bits 31:12, offset bits 11:0) |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 1 | Page absent or write not allowed |
| walk_req_valid | output | 1 | Table lookup launched |
| walk_req_vpn | output | 20 | Page number to look up |
| walk_cancel | output | 1 | Drop the launched lookup (hit) |
| walk_rsp_valid | input | 1 | Table entry returned |
| walk_rsp_present | input | 1 | Returned page is in memory |
| walk_rsp_writable | input | 1 | Returned page allows writes |
| walk_rsp_pfn | input | 20 | Returned frame number |

## Verification
Random traffic draws pages from a pool of 32 pages, twice the entry count. This mixes hits, misses and evictions, so a wrong victim choice appears as a hit or miss that disagrees with the model. Memory latencies vary from one to four cycles, which separates a response taken in the probe cycle from one taken while waiting. Directed cases cover:
- the same page at different offsets (install and offset pass-through);
- absent pages and read-only pages written, on both the miss and the hit path;
- a stray memory reply while idle;
- a flush;
- a fill of 17 distinct pages, which shows whether the rotating pointer or the free-entry search chose the victim.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_WAIT  = 2'd2
  } xlat_state_e;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]   fill_pfn,
  input  logic               fill_wr,
  output logic               hit,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [PFN_W-1:0]   hit_pfn,
  output logic               hit_wr,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [VPN_W-1:0] vpn_q [ENTRIES];
  logic [PFN_W-1:0] pfn_q [ENTRIES];
  logic             wr_q  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic we;
    logic valid_d;
    assign we = fill_en && (fill_idx == IDX_W'(g));

    always_comb begin
      valid_d = valid_vec[g];
      if (flush)   valid_d = 1'b0;
      else if (we) valid_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_vec[g] <= 1'b0;
      else        valid_vec[g] <= valid_d;
    end

    always_ff @(posedge clk) begin
      if (we) begin
        vpn_q[g] <= fill_vpn;
        pfn_q[g] <= fill_pfn;
        wr_q[g]  <= fill_wr;
      end
    end

    assign hit_vec[g] = valid_vec[g] && (vpn_q[g] == lk_vpn);
  end

  always_comb begin
    hit_pfn = '0;
    hit_wr  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_pfn = hit_pfn | pfn_q[i];
        hit_wr  = hit_wr | wr_q[i];
      end
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_en,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim_idx = any_free ? free_idx : ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    if (fill_en && !any_free) begin
      if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_d = '0;
      else                              ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic hit,
  input  logic walk_rsp_valid,
  output logic req_ready,
  output logic accept,
  output logic hit_done,
  output logic walk_done
);
  xlat_state_e st_q, st_d;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit_done  = (st_q == ST_PROBE) && hit;
  assign walk_done = (((st_q == ST_PROBE) && !hit) || (st_q == ST_WAIT)) && walk_rsp_valid;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_PROBE;
      ST_PROBE: if (hit || walk_rsp_valid) st_d = ST_IDLE;
                else                       st_d = ST_WAIT;
      ST_WAIT:  if (walk_rsp_valid) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VPN_W+OFF_W-1:0] req_vaddr,
  input  logic                   req_write,
  output logic                   rsp_valid,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output logic                   rsp_fault,
  output logic                   walk_req_valid,
  output logic [VPN_W-1:0]       walk_req_vpn,
  output logic                   walk_cancel,
  input  logic                   walk_rsp_valid,
  input  logic                   walk_rsp_present,
  input  logic                   walk_rsp_writable,
  input  logic [PFN_W-1:0]       walk_rsp_pfn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;

  logic               accept, hit_done, walk_done;
  logic               cam_hit, cam_hit_wr;
  logic [ENTRIES-1:0] cam_hit_vec, cam_valid;
  logic [PFN_W-1:0]   cam_hit_pfn;
  logic [IDX_W-1:0]   victim_idx;
  logic               fill_en;

  logic [VPN_W-1:0]   pend_vpn_q;
  logic [OFF_W-1:0]   pend_off_q;
  logic               pend_wr_q;

  logic               rsp_valid_d, rsp_fault_d;
  logic [PA_W-1:0]    rsp_paddr_d;

  xlat_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .hit            (cam_hit),
    .walk_rsp_valid (walk_rsp_valid),
    .req_ready      (req_ready),
    .accept         (accept),
    .hit_done       (hit_done),
    .walk_done      (walk_done)
  );

  assign fill_en = walk_done && walk_rsp_present && !flush;

  xlat_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lk_vpn    (pend_vpn_q),
    .fill_en   (fill_en),
    .fill_idx  (victim_idx),
    .fill_vpn  (pend_vpn_q),
    .fill_pfn  (walk_rsp_pfn),
    .fill_wr   (walk_rsp_writable),
    .hit       (cam_hit),
    .hit_vec   (cam_hit_vec),
    .hit_pfn   (cam_hit_pfn),
    .hit_wr    (cam_hit_wr),
    .valid_vec (cam_valid)
  );

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (cam_valid),
    .fill_en    (fill_en),
    .victim_idx (victim_idx)
  );

  // Lookup launched alongside the probe.
  assign walk_req_valid = accept;
  assign walk_req_vpn   = req_vaddr[VA_W-1:OFF_W];
  assign walk_cancel    = hit_done;

  always_ff @(posedge clk) begin
    if (accept) begin
      pend_vpn_q <= req_vaddr[VA_W-1:OFF_W];
      pend_off_q <= req_vaddr[OFF_W-1:0];
      pend_wr_q  <= req_write;
    end
  end

  always_comb begin
    rsp_valid_d = hit_done || walk_done;
    rsp_fault_d = 1'b0;
    rsp_paddr_d = '0;
    if (hit_done) begin
      rsp_fault_d = pend_wr_q && !cam_hit_wr;
      if (!rsp_fault_d) rsp_paddr_d = {cam_hit_pfn, pend_off_q};
    end else if (walk_done) begin
      rsp_fault_d = !walk_rsp_present || (pend_wr_q && !walk_rsp_writable);
      if (!rsp_fault_d) rsp_paddr_d = {walk_rsp_pfn, pend_off_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= rsp_valid_d;
  end

  always_ff @(posedge clk) begin
    if (rsp_valid_d) begin
      rsp_fault <= rsp_fault_d;
      rsp_paddr <= rsp_paddr_d;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [VPN_W+OFF_W-1:0] req_vaddr,
  input logic                   walk_req_valid,
  input logic                   walk_cancel,
  input logic                   rsp_valid,
  input logic                   rsp_fault,
  input logic [PFN_W+OFF_W-1:0] rsp_paddr,
  input logic [ENTRIES-1:0]     hit_vec
);
  logic [OFF_W-1:0] cap_off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cap_off_q <= '0;
    else if (req_valid && req_ready) cap_off_q <= req_vaddr[OFF_W-1:0];
  end

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3
  cancel_then_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_cancel |=> rsp_valid);

  // R3
  cancel_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_cancel |-> !req_ready);

  // R2
  launch_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |-> (req_ready && req_valid));

  // R5
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R6
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == cap_off_q));
endmodule

bind xlat_cache xlat_cache_chk #(
  .ENTRIES (ENTRIES),
  .VPN_W   (VPN_W),
  .OFF_W   (OFF_W),
  .PFN_W   (PFN_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_vaddr      (req_vaddr),
  .walk_req_valid (walk_req_valid),
  .walk_cancel    (walk_cancel),
  .rsp_valid      (rsp_valid),
  .rsp_fault      (rsp_fault),
  .rsp_paddr      (rsp_paddr),
  .hit_vec        (cam_hit_vec)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
  localparam int N     = 16;
  localparam int VPN_W = 20;
  localparam int OFF_W = 12;
  localparam int PFN_W = 20;

  logic                   clk, rst_n, flush;
  logic                   req_valid, req_ready, req_write;
  logic [VPN_W+OFF_W-1:0] req_vaddr;
  logic                   rsp_valid, rsp_fault;
  logic [PFN_W+OFF_W-1:0] rsp_paddr;
  logic                   walk_req_valid, walk_cancel;
  logic [VPN_W-1:0]       walk_req_vpn;
  logic                   walk_rsp_valid, walk_rsp_present, walk_rsp_writable;
  logic [PFN_W-1:0]       walk_rsp_pfn;

  int checks = 0;
  int errors = 0;

  xlat_cache u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .walk_req_valid(walk_req_valid),
    .walk_req_vpn(walk_req_vpn), .walk_cancel(walk_cancel),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_present(walk_rsp_present),
    .walk_rsp_writable(walk_rsp_writable), .walk_rsp_pfn(walk_rsp_pfn)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model of cached entries
  logic [VPN_W-1:0] m_vpn [N];
  logic [PFN_W-1:0] m_pfn [N];
  bit               m_wr  [N];
  bit               m_val [N];
  int               m_ptr;

  function automatic bit pt_present(input logic [VPN_W-1:0] v);
    return (v % 7) != 0;
  endfunction
  function automatic bit pt_writable(input logic [VPN_W-1:0] v);
    return (v % 3) != 0;
  endfunction
  function automatic logic [PFN_W-1:0] pt_pfn(input logic [VPN_W-1:0] v);
    return PFN_W'((v * 37 + 'h155) & 'hFFFFF);
  endfunction

  function automatic int m_find(input logic [VPN_W-1:0] v);
    for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic m_fill(input logic [VPN_W-1:0] v);
    int idx = -1;
    for (int i = N - 1; i >= 0; i--) if (!m_val[i]) idx = i;
    if (idx < 0) begin
      idx = m_ptr;
      m_ptr = (m_ptr + 1) % N;
    end
    m_val[idx] = 1'b1;
    m_vpn[idx] = v;
    m_pfn[idx] = pt_pfn(v);
    m_wr[idx]  = pt_writable(v);
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                        input bit wr, input int lat, input string tag);
    int  idx;
    bit  exp_fault;
    logic [PFN_W+OFF_W-1:0] exp_pa;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = {vpn, off};
    req_write = wr;
    #1;
    chk({tag, " R10 ready idle"}, req_ready, 1);
    chk({tag, " R2 launch"}, walk_req_valid, 1);
    chk({tag, " R2 vpn"}, walk_req_vpn, vpn);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    idx = m_find(vpn);
    chk({tag, " R3/R4 cancel"}, walk_cancel, idx >= 0);
    chk({tag, " R10 busy"}, req_ready, 0);
    chk({tag, " R2 no relaunch"}, walk_req_valid, 0);
    if (idx >= 0) begin
      exp_fault = wr && !m_wr[idx];
      exp_pa    = exp_fault ? '0 : {m_pfn[idx], off};
      @(negedge clk);
      #1;
      chk({tag, " R3 rsp_valid"}, rsp_valid, 1);
    end else begin
      exp_fault = !pt_present(vpn) || (wr && !pt_writable(vpn));
      exp_pa    = exp_fault ? '0 : {pt_pfn(vpn), off};
      for (int k = 1; k < lat; k++) begin
        @(negedge clk);
        #1;
        chk({tag, " R4 wait no rsp"}, rsp_valid, 0);
        chk({tag, " R10 busy wait"}, req_ready, 0);
      end
      walk_rsp_valid    = 1'b1;
      walk_rsp_present  = pt_present(vpn);
      walk_rsp_writable = pt_writable(vpn);
      walk_rsp_pfn      = pt_pfn(vpn);
      @(negedge clk);
      walk_rsp_valid = 1'b0;
      #1;
      chk({tag, " R4 rsp_valid"}, rsp_valid, 1);
      if (pt_present(vpn)) m_fill(vpn);
    end
    chk({tag, " R6/R7 fault"}, rsp_fault, exp_fault);
    chk({tag, " R1 paddr"}, rsp_paddr, exp_pa);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VPN_W-1:0] plist [N+1];
    int cnt;
    void'($urandom(32'd1234));
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0;
    walk_rsp_valid = 1'b0; walk_rsp_present = 1'b0; walk_rsp_writable = 1'b0;
    walk_rsp_pfn = '0;
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R11 reset state
    chk("R11 ready", req_ready, 1);
    chk("R11 rsp_valid", rsp_valid, 0);
    chk("R11 cancel", walk_cancel, 0);
    do_req(20'h00101, 12'h123, 1'b0, 2, "R11 first miss");

    // R5 other offset in a cached page hits
    do_req(20'h00101, 12'hABC, 1'b0, 2, "R5 same page");
    do_req(20'h00101, 12'h000, 1'b0, 2, "R5 offset zero");

    // R6 absent page: fault, then misses again
    do_req(20'h00007, 12'h010, 1'b0, 3, "R6 absent");
    do_req(20'h00007, 12'h020, 1'b0, 1, "R6 absent again");

    // R7 write to read-only page (vpn % 3 == 0)
    do_req(20'h00009, 12'h044, 1'b1, 2, "R7 write miss");
    do_req(20'h00009, 12'h048, 1'b0, 2, "R7 read hit");
    do_req(20'h00009, 12'h04C, 1'b1, 2, "R7 write hit");
    do_req(20'h0000A, 12'h004, 1'b1, 1, "R7 writable page");

    // R4 stray memory reply while idle
    @(negedge clk);
    walk_rsp_valid = 1'b1; walk_rsp_present = 1'b1; walk_rsp_pfn = 20'h12345;
    @(negedge clk);
    walk_rsp_valid = 1'b0;
    #1;
    chk("R4 stray reply ignored", rsp_valid, 0);
    chk("R4 stray ready", req_ready, 1);

    // R9 flush empties the cache
    do_flush();
    do_req(20'h00101, 12'h555, 1'b0, 2, "R9 after flush");

    // R8 free-first then rotating replacement
    do_flush();
    cnt = 0;
    for (int v = 'h400; cnt < N + 1; v++) begin
      if (pt_present(VPN_W'(v))) begin
        plist[cnt] = VPN_W'(v);
        cnt++;
      end
    end
    for (int i = 0; i < N + 1; i++) do_req(plist[i], 12'h0F0, 1'b0, 2, "R8 fill");
    do_req(plist[2], 12'h001, 1'b0, 2, "R8 kept entry");
    do_req(plist[N], 12'h002, 1'b0, 2, "R8 newest entry");
    do_req(plist[0], 12'h003, 1'b0, 2, "R8 evicted entry");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [VPN_W-1:0] v;
      if ($urandom % 40 == 0) do_flush();
      v = VPN_W'('h100 + ($urandom % 32));
      do_req(v, OFF_W'($urandom), bit'($urandom % 2), 1 + int'($urandom % 4), "R1 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule